// File: doc/BRIEF.md
# Delta Sample Memory Reader

This block is the memory side of a 1-bit delta-modulation audio channel. Software programs a compact start-address code, a compact length code and two flags (interrupt enable and loop). It then switches playback on. The reader turns the codes into a full byte address and a byte count. It fetches sample bytes one at a time from a bus-access unit and parks each byte in a one-byte sample buffer, where the downstream output unit collects it.

A fetch starts only when the buffer is empty and bytes are still owed. The fetch uses a request/acknowledge handshake of any latency, and only one request is in flight at a time. Addresses step upward and fold from the top of memory back into the middle. When the last byte of a sample has been fetched, the reader either starts the sample again (loop) or raises an interrupt flag. The flag drives the IRQ output until software clears it.

Top module: `dmr_reader`

## Requirements
- R1: The start address is 0xC000 + 64 × (address code). That is, the two top bits are 1, the 8-bit code sits at bits 13:6, and bits 5:0 are zero. The first byte fetched after playback starts comes from this address.
- R2: A sample is 16 × (length code) + 1 bytes long. Exactly that many bytes are fetched, after which no further request is made.
- R3: Each fetch reads the next sequential address. An increment from 0xFFFF wraps to 0x8000.
- R4: At most one request is outstanding. `fetch_req` and `fetch_addr` hold steady until `fetch_ack` is seen.
- R5: The sample buffer is either empty or holds one byte. Only an acknowledged fetch fills it, and only `smp_take` empties it. A held byte does not change until it is taken.
- R6: A request is raised only when the buffer is empty and bytes remain.
- R7: With the loop flag set, fetching the last byte reloads the start address and length. Playback continues from the start, and no interrupt is raised.
- R8: Without looping and with interrupt enable set, fetching the last byte sets the interrupt flag. `irq` stays high until a flags write with bit 7 at 0 clears it.
- R9: Turning playback on while no bytes remain restarts the sample, and turning it on during playback has no effect. Turning playback off sets the remaining count to zero and leaves a byte already in the buffer untouched.
- R10: `busy` is high exactly while the remaining byte count is nonzero. It is low after reset.
- R11: Register writes select a target with `reg_sel`: 0 selects the flags (bit 7 interrupt enable, bit 6 loop), 1 selects the address code, 2 selects the length code, and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| play_wr | input | 1 | Playback control write strobe |
| play_on | input | 1 | 1 turns playback on, 0 turns it off |
| fetch_req | output | 1 | Fetch request to the bus unit |
| fetch_addr | output | 16 | Address of the requested byte |
| fetch_ack | input | 1 | Bus unit returns the byte this cycle |
| fetch_data | input | 8 | Returned byte |
| smp_valid | output | 1 | Sample buffer holds a byte |
| smp_data | output | 8 | Buffered byte |
| smp_take | input | 1 | Output unit empties the buffer |
| irq | output | 1 | Interrupt line, high while the flag is set |
| busy | output | 1 | Bytes remain in the current sample |

## Verification
The sweep covers address codes at the bottom, middle and top of the code range, crossed with lengths of 1, 17 and 65 bytes. The bus latency rotates from 0 to 3 cycles. Each returned byte is a function of its address, so a wrong start, a wrong step or a missed wrap all show up as data mismatches. The byte count and the interrupt both depend on the exact length.

A long looping sample from the top code checks the 0xFFFF wrap and the restart, and confirms that looping raises no interrupt. A separate run turns playback on a second time during playback, then off while a byte waits in the buffer, then on again. This tells a correct stop and restart apart from a reader that drops the buffered byte or restarts at the wrong moment.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int CODE_W    = 8;
    localparam int ALIGN_W   = 6;
    localparam int LEN_SHIFT = 4;
    localparam int LEN_W     = CODE_W + LEN_SHIFT;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_LEN   = 2'd2,
        SEL_NONE  = 2'd3
    } sel_e;

    typedef struct packed {
        logic irq_en;
        logic loop;
    } flags_t;

    localparam int FLAG_IRQ_BIT  = 7;
    localparam int FLAG_LOOP_BIT = 6;

    function automatic addr_t start_of(code_t c);
        addr_t a;
        a = '1;
        a[ALIGN_W +: CODE_W] = c;
        a[ALIGN_W-1:0] = '0;
        return a;
    endfunction

    function automatic len_t length_of(code_t c);
        return len_t'({c, {LEN_SHIFT{1'b0}}}) + len_t'(1);
    endfunction

    function automatic addr_t step(addr_t a);
        if (a == '1)
            return {1'b1, {(ADDR_W-1){1'b0}}};
        return a + addr_t'(1);
    endfunction
endpackage

// File: rtl/dmr_regs.sv
module dmr_regs
    import dmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [1:0]      reg_sel,
    input  logic [CODE_W-1:0] reg_wdata,
    output flags_t          flags,
    output addr_t           start_addr,
    output len_t            length,
    output logic            irq_clr
);
    code_t  addr_code;
    code_t  len_code;
    sel_e   sel;

    assign sel = sel_e'(reg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags     <= '0;
            addr_code <= '0;
            len_code  <= '0;
        end else if (reg_wr) begin
            case (sel)
                SEL_FLAGS: begin
                    flags.irq_en <= reg_wdata[FLAG_IRQ_BIT];
                    flags.loop   <= reg_wdata[FLAG_LOOP_BIT];
                end
                SEL_ADDR: addr_code <= reg_wdata;
                SEL_LEN:  len_code  <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign start_addr = start_of(addr_code);
    assign length     = length_of(len_code);
    assign irq_clr    = reg_wr && (sel == SEL_FLAGS) && !reg_wdata[FLAG_IRQ_BIT];

    a_r11_ignore_sel3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd3) |=> ($stable(flags) && $stable(start_addr) && $stable(length)));
endmodule

// File: rtl/dmr_fetch.sv
module dmr_fetch
    import dmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   play_wr,
    input  logic   play_on,
    input  flags_t flags,
    input  addr_t  start_addr,
    input  len_t   length,
    input  logic   buf_valid,
    input  logic   fetch_ack,
    output logic   fetch_req,
    output addr_t  fetch_addr,
    output logic   fill,
    output logic   end_irq,
    output logic   busy
);
    addr_t cur_addr;
    len_t  remain;
    logic  pending;
    logic  stop;
    logic  restart;
    logic  ack_hit;
    logic  last;
    logic  launch;

    assign stop    = play_wr && !play_on;
    assign restart = play_wr && play_on && (remain == '0);
    assign ack_hit = pending && fetch_ack;
    assign last    = (remain == len_t'(1));
    assign launch  = !pending && !buf_valid && (remain != '0) && !stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (ack_hit) begin
            pending <= 1'b0;
        end else if (launch) begin
            pending <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (stop) begin
            remain <= '0;
        end else if (restart) begin
            cur_addr <= start_addr;
            remain   <= length;
        end else if (ack_hit && remain != '0) begin
            if (last && flags.loop) begin
                cur_addr <= start_addr;
                remain   <= length;
            end else begin
                cur_addr <= step(cur_addr);
                remain   <= remain - len_t'(1);
            end
        end
    end

    assign fetch_req  = pending;
    assign fetch_addr = cur_addr;
    assign fill       = ack_hit;
    assign busy       = (remain != '0);
    assign end_irq    = ack_hit && !stop && last && !flags.loop && flags.irq_en;

    a_r4_hold_req: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));
    a_r6_launch_cond: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_req) |-> $past(!buf_valid && busy));
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && !stop && cur_addr == '1 && remain > len_t'(1)) |=>
        (fetch_addr == {1'b1, {(ADDR_W-1){1'b0}}}));
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && !stop && last && flags.loop) |=> (remain == $past(length)));
    a_r9_stop_clears: assert property (@(posedge clk) disable iff (rst)
        stop |=> !busy);
endmodule

// File: rtl/dmr_buffer.sv
module dmr_buffer
    import dmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fill,
    input  data_t fill_data,
    input  logic  take,
    output logic  valid,
    output data_t data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (fill) begin
            valid <= 1'b1;
            data  <= fill_data;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

    a_r5_keep_byte: assert property (@(posedge clk) disable iff (rst)
        (valid && !take) |=> (valid && $stable(data)));
    a_r5_fill_empty: assert property (@(posedge clk) disable iff (rst)
        fill |-> !valid);
endmodule

// File: rtl/dmr_irq.sv
module dmr_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (clr)
            irq <= 1'b0;
        else if (set)
            irq <= 1'b1;
    end

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> !irq);
endmodule

// File: rtl/dmr_reader.sv
module dmr_reader
    import dmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [1:0]          reg_sel,
    input  logic [CODE_W-1:0]   reg_wdata,
    input  logic                play_wr,
    input  logic                play_on,
    output logic                fetch_req,
    output logic [ADDR_W-1:0]   fetch_addr,
    input  logic                fetch_ack,
    input  logic [DATA_W-1:0]   fetch_data,
    output logic                smp_valid,
    output logic [DATA_W-1:0]   smp_data,
    input  logic                smp_take,
    output logic                irq,
    output logic                busy
);
    flags_t flags;
    addr_t  start_addr;
    len_t   length;
    logic   irq_clr;
    logic   fill;
    logic   end_irq;

    dmr_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .flags(flags), .start_addr(start_addr),
        .length(length), .irq_clr(irq_clr)
    );

    dmr_fetch u_fetch (
        .clk(clk), .rst(rst), .play_wr(play_wr), .play_on(play_on),
        .flags(flags), .start_addr(start_addr), .length(length),
        .buf_valid(smp_valid), .fetch_ack(fetch_ack), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fill(fill), .end_irq(end_irq), .busy(busy)
    );

    dmr_buffer u_buf (
        .clk(clk), .rst(rst), .fill(fill), .fill_data(fetch_data),
        .take(smp_take), .valid(smp_valid), .data(smp_data)
    );

    dmr_irq u_irq (
        .clk(clk), .rst(rst), .set(end_irq), .clr(irq_clr), .irq(irq)
    );

    a_r10_busy_reset: assert property (@(posedge clk)
        $past(rst) |-> !busy);
endmodule

// File: tb/test_dmr_reader.sv
module test_dmr_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        play_wr = 1'b0;
    logic        play_on = 1'b0;
    logic        fetch_req;
    logic [15:0] fetch_addr;
    logic        fetch_ack;
    logic [7:0]  fetch_data;
    logic        smp_valid;
    logic [7:0]  smp_data;
    logic        smp_take = 1'b0;
    logic        irq;
    logic        busy;

    int n_chk = 0;
    int n_err = 0;
    int lat = 0;
    int cnt = 0;

    always #2.5 clk = ~clk;

    dmr_reader i_dmr_reader (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .play_wr(play_wr), .play_on(play_on),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
        .fetch_data(fetch_data), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_take(smp_take), .irq(irq), .busy(busy)
    );

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return a[7:0] + (a[15:8] * 8'd3) + 8'h5A;
    endfunction

    function automatic logic [15:0] next_a(logic [15:0] a);
        return (a == 16'hFFFF) ? 16'h8000 : a + 16'd1;
    endfunction

    assign fetch_data = mem_byte(fetch_addr);

    always @(posedge clk) begin
        if (rst) begin
            fetch_ack <= 1'b0;
            cnt <= 0;
        end else begin
            fetch_ack <= 1'b0;
            if (fetch_req && !fetch_ack) begin
                if (cnt >= lat) begin
                    fetch_ack <= 1'b1;
                    cnt <= 0;
                    lat <= (lat + 1) % 4;
                end else begin
                    cnt <= cnt + 1;
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] s, logic [7:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic play(logic on);
        play_wr = 1'b1; play_on = on;
        @(negedge clk);
        play_wr = 1'b0;
    endtask

    task automatic take_expect(logic [15:0] ea, string tag);
        int w = 0;
        while (!smp_valid && w < 300) begin
            @(negedge clk);
            w++;
        end
        chk(smp_valid && smp_data == mem_byte(ea), tag, int'(smp_data), int'(mem_byte(ea)));
        smp_take = 1'b1;
        @(negedge clk);
        smp_take = 1'b0;
    endtask

    task automatic run_once(logic [7:0] ac, logic [7:0] lc, bit irqen);
        logic [15:0] a;
        int n;
        a = 16'hC000 + {2'b00, ac, 6'b000000};
        n = int'(lc) * 16 + 1;
        wr_reg(2'd1, ac);
        wr_reg(2'd2, lc);
        wr_reg(2'd0, irqen ? 8'h80 : 8'h00);
        play(1'b1);
        for (int i = 0; i < n; i++) begin
            if (i == 0) take_expect(a, "R1");
            else take_expect(a, "R3");
            if (i == 0) chk(busy == (n > 1), "R10", int'(busy), int'(n > 1));
            a = next_a(a);
        end
        repeat (20) @(negedge clk);
        chk(!smp_valid && !fetch_req, "R2", int'(smp_valid), 0);
        chk(!busy, "R10", int'(busy), 0);
        chk(irq == irqen, "R8", int'(irq), int'(irqen));
        if (irqen) begin
            wr_reg(2'd3, 8'h00);
            chk(irq == 1'b1, "R11", int'(irq), 1);
            wr_reg(2'd0, 8'h40);
            chk(irq == 1'b0, "R8", int'(irq), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] codes [5];
        logic [7:0] lens [3];
        logic [15:0] a;
        logic [15:0] s;
        logic [7:0] held;
        codes = '{8'h00, 8'h01, 8'h80, 8'hFE, 8'hFF};
        lens  = '{8'h00, 8'h01, 8'h04};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!fetch_req && !smp_valid && !irq && !busy, "R10", int'(busy), 0);

        for (int c = 0; c < 5; c++)
            for (int l = 0; l < 3; l++)
                run_once(codes[c], lens[l], ((c + l) % 2) == 1);

        // Loop across the 0xFFFF wrap with interrupt enabled: R7
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd2, 8'h04);
        wr_reg(2'd0, 8'hC0);
        play(1'b1);
        s = 16'hFFC0;
        a = s;
        for (int i = 0; i < 65 + 6; i++) begin
            take_expect(a, "R7");
            a = (i % 65 == 64) ? s : next_a(a);
        end
        chk(!irq && busy, "R7", int'(irq), 0);
        play(1'b0);
        repeat (20) @(negedge clk);
        if (smp_valid) take_expect(a, "R9");
        repeat (20) @(negedge clk);
        chk(!fetch_req && !smp_valid && !busy, "R9", int'(busy), 0);

        // Enable during playback, then stop with a byte held: R9
        wr_reg(2'd1, 8'h10);
        wr_reg(2'd2, 8'h01);
        wr_reg(2'd0, 8'h40);
        play(1'b1);
        s = 16'hC400;
        take_expect(s, "R9");
        play(1'b1);
        take_expect(s + 16'd1, "R9");
        while (!smp_valid) @(negedge clk);
        held = smp_data;
        repeat (4) @(negedge clk);
        play(1'b0);
        chk(smp_valid && smp_data == held, "R9", int'(smp_data), int'(held));
        chk(!busy, "R9", int'(busy), 0);
        repeat (5) @(negedge clk);
        chk(smp_valid && smp_data == held, "R5", int'(smp_data), int'(held));
        chk(held == mem_byte(s + 16'd2), "R5", int'(held), int'(mem_byte(s + 16'd2)));
        smp_take = 1'b1;
        @(negedge clk);
        smp_take = 1'b0;
        repeat (30) @(negedge clk);
        chk(!smp_valid && !fetch_req, "R9", int'(smp_valid), 0);
        play(1'b1);
        take_expect(s, "R9");
        play(1'b0);
        repeat (20) @(negedge clk);
        if (smp_valid) begin
            smp_take = 1'b1;
            @(negedge clk);
            smp_take = 1'b0;
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule